// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns supply-status and push-button inputs into a clean processor reset. An external comparator reports a "supply below threshold" condition as a synchronous digital flag. A push-button or any logic source drives an active-low manual request. The block produces an active-low reset and its active-high complement. Reset is held for as long as any cause is present. After the last cause goes away, reset stays asserted for a programmed number of cycles before it is released.

Each cause sets its own release count. A supply event needs the release interval. A manual request needs the minimum-stretch interval, and this interval is also what debounces a bouncing switch. A supply dip that arrives while a pulse is already counting down adds the minimum-stretch interval to the requirement. The release counter starts again from zero every time a cause clears. Reset is released when the counter reaches the largest interval among the causes seen during the current pulse. An asynchronous power-on reset starts the block with reset asserted and the supply interval pending.

Top module: `sup_rst_gen`

## Requirements
- R1: While `supply_low_i` is 1 at a rising clock edge, `rst_no` is 0 after that edge. A supply flag raised from the idle state asserts reset after the first edge that samples it.
- R2: When a pulse was caused only by the supply flag (or by power-on), `rst_no` returns to 1 after exactly `REL_CYC` consecutive edges that sample `supply_low_i` low. After `REL_CYC-1` such edges it is still 0.
- R3: If `supply_low_i` rises while a pulse is already counting down, the release needs max(`REL_CYC`, `STR_CYC`) edges after the flag clears again.
- R4: `mr_ni` passes through a two-flop synchronizer. A low level asserts reset after the third rising edge that follows it, and not earlier.
- R5: After the synchronized manual request returns high, reset is released after `STR_CYC` counting edges, which is `STR_CYC+2` edges after `mr_ni` rises. A manual low lasting a single cycle still gives a reset pulse of `STR_CYC` cycles.
- R6: `rst_o` is at all times the logical complement of `rst_no`.
- R7: While `rst_ni` is 0, `rst_no` is 0 and `rst_o` is 1. After `rst_ni` is released with no cause present, reset is released after `REL_CYC` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| supply_low_i | input | 1 | Supply-below-threshold flag, synchronous to clk_i |
| mr_ni | input | 1 | Manual reset request, active low, asynchronous |
| rst_no | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |

## Verification
The bench builds the block with `REL_CYC=30` and `STR_CYC=50`. With these values every release edge can be checked cycle by cycle in a short run. Because the stretch interval is longer than the release interval, a re-armed brownout or a manual pulse releases visibly later than a plain supply event. A release taken from the wrong interval therefore shows up as a timing error, not as a pulse that merely meets a minimum.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RESET_VAL;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RESET_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sup_rst_arm.sv
// Records which causes touched the current pulse and derives the release target.
module sup_rst_arm #(
  parameter int unsigned REL_CYC = 200000,
  parameter int unsigned STR_CYC = 140000,
  parameter int unsigned CNT_W   = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_low_i,
  input  logic             mr_low_i,
  input  logic             active_i,
  output logic             hold_o,
  output logic [CNT_W-1:0] target_o
);
  logic sup_q, mr_q, rearm_q, hold_q;
  logic sup_d, mr_d, rearm_d;
  logic [CNT_W-1:0] rel_t, str_t;

  assign hold_o = supply_low_i | mr_low_i;

  // flags survive only while the pulse is active
  assign sup_d   = supply_low_i | (active_i & sup_q);
  assign mr_d    = mr_low_i | (active_i & mr_q);
  assign rearm_d = (supply_low_i & active_i & ~hold_q) | (active_i & rearm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sup_q   <= 1'b1;
      mr_q    <= 1'b0;
      rearm_q <= 1'b0;
      hold_q  <= 1'b1;
    end else begin
      sup_q   <= sup_d;
      mr_q    <= mr_d;
      rearm_q <= rearm_d;
      hold_q  <= hold_o;
    end
  end

  assign rel_t = sup_q ? CNT_W'(REL_CYC) : CNT_W'(1);
  assign str_t = (mr_q | rearm_q) ? CNT_W'(STR_CYC) : CNT_W'(1);

  always_comb begin
    target_o = (rel_t > str_t) ? rel_t : str_t;
    if (target_o == '0) target_o = CNT_W'(1);
  end
endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             active_o,
  output logic             active_d_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_nxt;
  logic             active_q;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    if (hold_i) begin
      cnt_d      = '0;
      active_d_o = 1'b1;
    end else if (active_q) begin
      cnt_d      = cnt_nxt[CNT_W-1:0];
      active_d_o = cnt_nxt < {1'b0, target_i};
    end else begin
      cnt_d      = '0;
      active_d_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d_o;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/sup_rst_out.sv
module sup_rst_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_d_i,
  output logic rst_no,
  output logic rst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_no <= 1'b0;
      rst_o  <= 1'b1;
    end else begin
      rst_no <= ~active_d_i;
      rst_o  <= active_d_i;
    end
  end
endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen #(
  parameter int unsigned REL_CYC     = 200000,
  parameter int unsigned STR_CYC     = 140000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_low_i,
  input  logic mr_ni,
  output logic rst_no,
  output logic rst_o
);
  import sup_rst_pkg::*;

  localparam int unsigned MAX_CYC = max_u(REL_CYC, STR_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             mr_sync;
  logic             hold;
  logic             active;
  logic             active_d;
  logic [CNT_W-1:0] target;

  sup_rst_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mr_ni),
    .q_o   (mr_sync)
  );

  sup_rst_arm #(.REL_CYC(REL_CYC), .STR_CYC(STR_CYC), .CNT_W(CNT_W)) u_arm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_low_i(supply_low_i),
    .mr_low_i    (~mr_sync),
    .active_i    (active),
    .hold_o      (hold),
    .target_o    (target)
  );

  sup_rst_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold),
    .target_i  (target),
    .active_o  (active),
    .active_d_o(active_d)
  );

  sup_rst_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_d_i(active_d),
    .rst_no    (rst_no),
    .rst_o     (rst_o)
  );
endmodule

// File: rtl/sup_rst_gen_chk.sv
module sup_rst_gen_chk #(
  parameter int unsigned REL_CYC = 200000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_low_i,
  input logic mr_ni,
  input logic rst_no,
  input logic rst_o
);
  localparam int unsigned QW = $clog2(REL_CYC + 1);
  logic [QW-1:0] quiet_q;

  // edges with supply flag low since it last was high (saturating)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   quiet_q <= '0;
    else if (supply_low_i)         quiet_q <= '0;
    else if (quiet_q != QW'(REL_CYC)) quiet_q <= quiet_q + 1'b1;
  end

  AST_SUPPLY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(supply_low_i) |-> !rst_no); // R1

  AST_RELEASE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (quiet_q >= QW'(REL_CYC))); // R2

  AST_MANUAL_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(mr_ni, 3) && !$past(mr_ni, 2)) |-> !rst_no); // R4

  AST_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o == !rst_no); // R6
endmodule

bind sup_rst_gen sup_rst_gen_chk #(.REL_CYC(REL_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_low_i(supply_low_i),
  .mr_ni       (mr_ni),
  .rst_no      (rst_no),
  .rst_o       (rst_o)
);

// File: tb/sup_rst_gen_test.sv
`timescale 1ns/1ps
module sup_rst_gen_test;
  localparam int unsigned REL = 30;
  localparam int unsigned STR = 50;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_low = 1'b0;
  logic mr_n = 1'b1;
  logic rst_no, rst_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sup_rst_gen #(.REL_CYC(REL), .STR_CYC(STR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_low_i(supply_low),
    .mr_ni(mr_n), .rst_no(rst_no), .rst_o(rst_o)
  );

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rst(input logic exp_n, input string req);
    total++;
    if (rst_no !== exp_n) begin
      bad++;
      $display("FAIL %s rst_no act=%b exp=%b t=%0t", req, rst_no, exp_n, $time);
    end
    total++;
    if (rst_o !== ~exp_n) begin
      bad++;
      $display("FAIL R6 rst_o act=%b exp=%b t=%0t", rst_o, ~exp_n, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic t_power_on();
    edges(3);
    expect_rst(1'b0, "R7");
    rst_ni = 1'b1;
    edges(REL - 1);
    expect_rst(1'b0, "R7");
    edges(1);
    expect_rst(1'b1, "R7");
  endtask

  task automatic t_brownout_idle();
    supply_low = 1'b1;
    edges(1);
    expect_rst(1'b0, "R1");
    edges(5);
    expect_rst(1'b0, "R1");
    supply_low = 1'b0;
    edges(REL - 1);
    expect_rst(1'b0, "R2");
    edges(1);
    expect_rst(1'b1, "R2");
    edges(5);
  endtask

  task automatic t_long_low();
    supply_low = 1'b1;
    for (int i = 0; i < 5; i++) begin
      edges(20);
      expect_rst(1'b0, "R1");
    end
    supply_low = 1'b0;
    edges(REL);
    expect_rst(1'b1, "R2");
    edges(5);
  endtask

  task automatic t_rearm();
    supply_low = 1'b1;
    edges(1);
    supply_low = 1'b0;
    edges(10);
    expect_rst(1'b0, "R3");
    supply_low = 1'b1;
    edges(2);
    expect_rst(1'b0, "R3");
    supply_low = 1'b0;
    edges(REL);
    expect_rst(1'b0, "R3");
    edges(STR - 1 - REL);
    expect_rst(1'b0, "R3");
    edges(1);
    expect_rst(1'b1, "R3");
    edges(5);
  endtask

  task automatic t_manual();
    mr_n = 1'b0;
    edges(2);
    expect_rst(1'b1, "R4");
    edges(1);
    expect_rst(1'b0, "R4");
    edges(4);
    mr_n = 1'b1;
    edges(STR + 1);
    expect_rst(1'b0, "R5");
    edges(1);
    expect_rst(1'b1, "R5");
    edges(5);
  endtask

  task automatic t_glitch();
    mr_n = 1'b0;
    edges(1);
    mr_n = 1'b1;
    edges(2);
    expect_rst(1'b0, "R5");
    edges(STR - 1);
    expect_rst(1'b0, "R5");
    edges(1);
    expect_rst(1'b1, "R5");
    edges(5);
  endtask

  initial begin
    t_power_on();
    t_brownout_idle();
    t_long_low();
    t_rearm();
    t_manual();
    t_glitch();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end
endmodule